// File: doc/BRIEF.md
# Module-Description Row Boundary Calculator

This block turns the description bytes of the memory modules plugged into a fixed number of sockets into the values a DRAM controller needs. These are the cumulative row boundaries and a per-socket row attribute code. After a start pulse it walks the sockets in order. For each socket it asks the serial-description transport for single bytes through a request/valid byte-read port. It checks whether the socket is populated and whether the module has the expected speed grade. It then decodes the size of each side from the density bitmask, demotes asymmetric modules to single-sided, checks the size limits, and derives the attribute code from the page size and the bank count.

Boundaries are in units of 32 MB and grow across sockets. The topmost value is copied into two extra entries above the last socket. A fault does not halt anything. Instead it latches an error flag, the failing socket and a cause code, and the block stops reading. A one-cycle done pulse marks a clean finish.

Top module: `spd_row_calc`

## Requirements
- R1: After start, sockets are handled in order 0 then 1. Each socket first reads byte 2. An unpopulated socket, where byte 2 is not 0x04, gets no further reads. A populated one then reads bytes 9, 10, 31, 5, 4, 6 in that order. A request holds its socket and index steady until `rd_valid_i`.
- R2: An unpopulated socket adds 0 to both of its boundary entries and gets attribute code 0xFF.
- R3: Side-1 size is the value of the highest set bit of byte 31, times 4 MB. When byte 5 > 1, side 2 equals side 1 if byte 31 has a single bit set. If byte 31 is side 1 plus exactly one lower bit, side 2 is that bit, which is then demoted to 0 (single-sided). Otherwise side 2 is 0.
- R4: Byte 9 must be 0x75 and byte 10 must be 0x54. Otherwise the error causes are 1 and 2, and these take top priority.
- R5: A side-1 size below 32 MB gives cause 3. A size above 256 MB gives cause 4. These are checked after the speed bytes.
- R6: Entries 2s and 2s+1 of `bnd_o` (bits [8k+7:8k] for entry k) hold base+side1 and base+side1+side2 in 32 MB units. Base is the last entry written by the socket before.
- R7: After the last socket, entries 4 and 5 both equal entry 3.
- R8: The page size in KB is 2^byte4 × byte6 / 8192. Single-bank modules (byte 5 = 1) map 2/4/8/16 KB to 0xF0..0xF3. Two-bank modules map them to 0x00, 0x11, 0x22, 0x33. The code is placed at `attr_o` bits [8s+7:8s].
- R9: A bank count other than 1 or 2 gives cause 5. Failing that, a page size outside {2,4,8,16} KB gives cause 6.
- R10: An error sets `err_o` with `err_sock_o` and `err_cause_o`, which hold until the next start. No further reads follow, there is no done pulse, and the entries of the failing and later sockets keep their cleared values (0 and 0xFF).
- R11: `done_o` pulses for exactly one cycle, in the cycle after the last socket's entries are written. Start clears all entries and any error.
- R12: Under reset `rd_req_o`, `done_o` and `err_o` are 0, all boundaries are 0 and all attribute codes are 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calculation pass |
| rd_req_o | output | 1 | Byte read request |
| rd_sock_o | output | SOCK_W | Socket of the requested byte |
| rd_idx_o | output | 8 | Byte index requested |
| rd_valid_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 8 | Read data |
| bnd_o | output | NUM_BND*BND_W | Row boundary entries, entry k at [k*BND_W +: BND_W] |
| attr_o | output | NUM_SOCK*8 | Row attribute code per socket |
| done_o | output | 1 | One-cycle pulse at clean completion |
| err_o | output | 1 | Error latched |
| err_sock_o | output | SOCK_W | Socket that failed |
| err_cause_o | output | 3 | Cause: 1 byte 9, 2 byte 10, 3 too small, 4 too large, 5 bank count, 6 page size |

## Verification
The bench targets the density decode with single-bit, two-bit and three-bit masks. A design that skips the demotion would report a side-2 size and shift every later boundary. The bench also covers empty sockets in either position, where a wrong design would keep reading or leave stale boundaries. Faults are raised with several causes at once to pin the priority order, and on socket 1 to show that socket 0's entries survive while reads stop. The top size (256 MB per side) and the page-size edges check for off-by-one limits and a wrong attribute for the bank count.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned NUM_STEPS = 7;
  localparam int unsigned STEP_W    = 3;
  localparam logic [7:0]  PRESENT_CODE = 8'h04;
  localparam logic [7:0]  SPEED_A_CODE = 8'h75;
  localparam logic [7:0]  SPEED_B_CODE = 8'h54;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_SPEED_A  = 3'd1,
    CAUSE_SPEED_B  = 3'd2,
    CAUSE_SMALL    = 3'd3,
    CAUSE_LARGE    = 3'd4,
    CAUSE_BANKS    = 3'd5,
    CAUSE_PAGE     = 3'd6
  } cause_e;

  // step order: presence, speed a, speed b, density, banks, columns, width
  typedef logic [NUM_STEPS-1:0][7:0] spd_bytes_t;

  function automatic logic [7:0] step_index(input logic [STEP_W-1:0] step);
    case (step)
      3'd0:    return 8'd2;
      3'd1:    return 8'd9;
      3'd2:    return 8'd10;
      3'd3:    return 8'd31;
      3'd4:    return 8'd5;
      3'd5:    return 8'd4;
      default: return 8'd6;
    endcase
  endfunction

  function automatic logic [7:0] top_bit(input logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 8'(1) << i;
    return r;
  endfunction
endpackage

// File: rtl/spd_seq.sv
module spd_seq
  import spd_pkg::*;
#(
  parameter int unsigned NUM_SOCK = 2,
  parameter int unsigned SOCK_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  input  logic              eval_err_i,
  input  logic [2:0]        eval_cause_i,
  output logic              rd_req_o,
  output logic [SOCK_W-1:0] sock_o,
  output logic [7:0]        rd_idx_o,
  output spd_bytes_t        bytes_o,
  output logic              clr_o,
  output logic              wr_o,
  output logic              last_o,
  output logic              done_o,
  output logic              err_o,
  output logic [SOCK_W-1:0] err_sock_o,
  output logic [2:0]        err_cause_o
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_EVAL, S_DONE, S_ERR} state_e;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [SOCK_W-1:0] LAST_SOCK = SOCK_W'(NUM_SOCK - 1);

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [SOCK_W-1:0] sock_q;
  spd_bytes_t        bytes_q;
  logic [SOCK_W-1:0] esock_q;
  logic [2:0]        ecause_q;

  assign clr_o  = start_i && (state_q == S_IDLE || state_q == S_DONE || state_q == S_ERR);
  assign last_o = (sock_q == LAST_SOCK);
  assign wr_o   = (state_q == S_EVAL) && !eval_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      step_q   <= '0;
      sock_q   <= '0;
      bytes_q  <= '0;
      esock_q  <= '0;
      ecause_q <= '0;
    end else if (clr_o) begin
      state_q  <= S_READ;
      step_q   <= '0;
      sock_q   <= '0;
      esock_q  <= '0;
      ecause_q <= '0;
    end else begin
      case (state_q)
        S_READ: if (rd_valid_i) begin
          bytes_q[step_q] <= rd_data_i;
          if ((step_q == '0 && rd_data_i != PRESENT_CODE) || step_q == LAST_STEP)
            state_q <= S_EVAL;
          else
            step_q <= step_q + 1'b1;
        end
        S_EVAL: begin
          if (eval_err_i) begin
            state_q  <= S_ERR;
            esock_q  <= sock_q;
            ecause_q <= eval_cause_i;
          end else if (last_o) begin
            state_q <= S_DONE;
          end else begin
            sock_q  <= sock_q + 1'b1;
            step_q  <= '0;
            state_q <= S_READ;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: ;
      endcase
    end
  end

  assign rd_req_o    = (state_q == S_READ);
  assign sock_o      = sock_q;
  assign rd_idx_o    = step_index(step_q);
  assign bytes_o     = bytes_q;
  assign done_o      = (state_q == S_DONE);
  assign err_o       = (state_q == S_ERR);
  assign err_sock_o  = esock_q;
  assign err_cause_o = ecause_q;
endmodule

// File: rtl/spd_eval.sv
module spd_eval
  import spd_pkg::*;
#(
  parameter int unsigned BND_W = 8
) (
  input  spd_bytes_t       bytes_i,
  output logic [BND_W-1:0] side1_o,
  output logic [BND_W-1:0] side2_o,
  output logic [7:0]       attr_o,
  output logic             err_o,
  output logic [2:0]       cause_o
);
  logic       present;
  logic [7:0] dens, banks, cols, width;
  logic [7:0] s1_bit, rest, s2_raw, s2_bit;
  logic [39:0] page_bits;
  logic [39:0] page_kb;
  logic        page_ok;
  logic [1:0]  page_idx;
  cause_e      cause;

  assign present = (bytes_i[0] == PRESENT_CODE);
  assign dens    = bytes_i[3];
  assign banks   = bytes_i[4];
  assign cols    = bytes_i[5];
  assign width   = bytes_i[6];

  always_comb begin
    s1_bit = top_bit(dens);
    rest   = dens & ~s1_bit;
    if (banks <= 8'd1)               s2_raw = '0;
    else if (rest == '0)             s2_raw = s1_bit;
    else if ($countones(rest) == 1)  s2_raw = rest;
    else                             s2_raw = '0;
    // asymmetric modules drop to single-sided
    s2_bit = (s2_raw != '0 && s2_raw != s1_bit) ? '0 : s2_raw;
  end

  always_comb begin
    page_bits = (40'd1 << cols[4:0]) * {32'd0, width};
    page_kb   = page_bits >> 13;
    page_ok   = (cols <= 8'd23);
    page_idx  = 2'd0;
    case (page_kb)
      40'd2:   page_idx = 2'd0;
      40'd4:   page_idx = 2'd1;
      40'd8:   page_idx = 2'd2;
      40'd16:  page_idx = 2'd3;
      default: page_ok  = 1'b0;
    endcase
  end

  always_comb begin
    if      (bytes_i[1] != SPEED_A_CODE)   cause = CAUSE_SPEED_A;
    else if (bytes_i[2] != SPEED_B_CODE)   cause = CAUSE_SPEED_B;
    else if (s1_bit < 8'd8)                cause = CAUSE_SMALL;
    else if (s1_bit > 8'd64)               cause = CAUSE_LARGE;
    else if (banks != 8'd1 && banks != 8'd2) cause = CAUSE_BANKS;
    else if (!page_ok)                     cause = CAUSE_PAGE;
    else                                   cause = CAUSE_NONE;
  end

  always_comb begin
    if (!present) begin
      side1_o = '0;
      side2_o = '0;
      attr_o  = 8'hFF;
      err_o   = 1'b0;
      cause_o = CAUSE_NONE;
    end else begin
      side1_o = BND_W'(s1_bit >> 3);
      side2_o = BND_W'(s2_bit >> 3);
      attr_o  = (banks == 8'd1) ? {4'hF, 2'b00, page_idx} : {2'b00, page_idx, 2'b00, page_idx};
      err_o   = (cause != CAUSE_NONE);
      cause_o = cause;
    end
  end
endmodule

// File: rtl/spd_regfile.sv
module spd_regfile #(
  parameter int unsigned NUM_SOCK = 2,
  parameter int unsigned SOCK_W   = 1,
  parameter int unsigned BND_W    = 8,
  localparam int unsigned NUM_BND = 2 * NUM_SOCK + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic                     last_i,
  input  logic [SOCK_W-1:0]        sock_i,
  input  logic [BND_W-1:0]         side1_i,
  input  logic [BND_W-1:0]         side2_i,
  input  logic [7:0]               attr_i,
  output logic [NUM_BND*BND_W-1:0] bnd_o,
  output logic [NUM_SOCK*8-1:0]    attr_o
);
  logic [BND_W-1:0] base_q, top_q, lo_nxt, hi_nxt;

  assign lo_nxt = base_q + side1_i;
  assign hi_nxt = lo_nxt + side2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      top_q  <= '0;
    end else if (clr_i) begin
      base_q <= '0;
      top_q  <= '0;
    end else if (wr_i) begin
      base_q <= hi_nxt;
      if (last_i) top_q <= hi_nxt;
    end
  end

  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
    logic [BND_W-1:0] lo_q, hi_q;
    logic [7:0]       at_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
        at_q <= 8'hFF;
      end else if (clr_i) begin
        lo_q <= '0;
        hi_q <= '0;
        at_q <= 8'hFF;
      end else if (wr_i && sock_i == SOCK_W'(g)) begin
        lo_q <= lo_nxt;
        hi_q <= hi_nxt;
        at_q <= attr_i;
      end
    end
    assign bnd_o[(2*g)*BND_W +: BND_W]   = lo_q;
    assign bnd_o[(2*g+1)*BND_W +: BND_W] = hi_q;
    assign attr_o[g*8 +: 8]              = at_q;
  end

  assign bnd_o[(NUM_BND-2)*BND_W +: BND_W] = top_q;
  assign bnd_o[(NUM_BND-1)*BND_W +: BND_W] = top_q;
endmodule

// File: rtl/spd_row_calc.sv
module spd_row_calc
  import spd_pkg::*;
#(
  parameter int unsigned NUM_SOCK = 2,
  parameter int unsigned BND_W    = 8,
  localparam int unsigned SOCK_W  = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
  localparam int unsigned NUM_BND = 2 * NUM_SOCK + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     rd_req_o,
  output logic [SOCK_W-1:0]        rd_sock_o,
  output logic [7:0]               rd_idx_o,
  input  logic                     rd_valid_i,
  input  logic [7:0]               rd_data_i,
  output logic [NUM_BND*BND_W-1:0] bnd_o,
  output logic [NUM_SOCK*8-1:0]    attr_o,
  output logic                     done_o,
  output logic                     err_o,
  output logic [SOCK_W-1:0]        err_sock_o,
  output logic [2:0]               err_cause_o
);
  spd_bytes_t       bytes;
  logic             clr, wr, last, eval_err;
  logic [2:0]       eval_cause;
  logic [BND_W-1:0] side1, side2;
  logic [7:0]       attr;

  spd_seq #(.NUM_SOCK(NUM_SOCK), .SOCK_W(SOCK_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .rd_valid_i, .rd_data_i,
    .eval_err_i(eval_err), .eval_cause_i(eval_cause),
    .rd_req_o, .sock_o(rd_sock_o), .rd_idx_o, .bytes_o(bytes),
    .clr_o(clr), .wr_o(wr), .last_o(last),
    .done_o, .err_o, .err_sock_o, .err_cause_o
  );

  spd_eval #(.BND_W(BND_W)) u_eval (
    .bytes_i(bytes), .side1_o(side1), .side2_o(side2), .attr_o(attr),
    .err_o(eval_err), .cause_o(eval_cause)
  );

  spd_regfile #(.NUM_SOCK(NUM_SOCK), .SOCK_W(SOCK_W), .BND_W(BND_W)) u_rf (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr), .last_i(last), .sock_i(rd_sock_o),
    .side1_i(side1), .side2_i(side2), .attr_i(attr), .bnd_o, .attr_o
  );
endmodule

// File: rtl/spd_row_calc_chk.sv
module spd_row_calc_chk #(
  parameter int unsigned NUM_SOCK = 2,
  parameter int unsigned BND_W    = 8,
  localparam int unsigned SOCK_W  = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
  localparam int unsigned NUM_BND = 2 * NUM_SOCK + 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     rd_req_o,
  input logic [SOCK_W-1:0]        rd_sock_o,
  input logic [7:0]               rd_idx_o,
  input logic                     rd_valid_i,
  input logic [NUM_BND*BND_W-1:0] bnd_o,
  input logic                     done_o,
  input logic                     err_o,
  input logic [SOCK_W-1:0]        err_sock_o,
  input logic [2:0]               err_cause_o
);
  assert_req_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_idx_o) && $stable(rd_sock_o));

  assert_top_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bnd_o[(NUM_BND-1)*BND_W +: BND_W] == bnd_o[(NUM_BND-3)*BND_W +: BND_W]
            && bnd_o[(NUM_BND-2)*BND_W +: BND_W] == bnd_o[(NUM_BND-3)*BND_W +: BND_W]);

  assert_err_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o && $stable(err_sock_o) && $stable(err_cause_o));

  assert_err_no_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rd_req_o && !done_o);

  assert_err_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_cause_o != 3'd0 && err_cause_o != 3'd7);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind spd_row_calc spd_row_calc_chk #(.NUM_SOCK(NUM_SOCK), .BND_W(BND_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .rd_req_o, .rd_sock_o, .rd_idx_o, .rd_valid_i,
  .bnd_o, .done_o, .err_o, .err_sock_o, .err_cause_o
);

// File: tb/spd_row_calc_bench.sv
module spd_row_calc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        rd_req_o, done_o, err_o;
  logic [0:0]  rd_sock_o, err_sock_o;
  logic [7:0]  rd_idx_o;
  logic [47:0] bnd_o;
  logic [15:0] attr_o;
  logic [2:0]  err_cause_o;

  spd_row_calc u_spd_row_calc (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] mem [2][256];
  int exp_bnd [6];
  int exp_attr [2];
  int exp_err, exp_sock, exp_cause;
  int q_sock [$];
  int q_idx [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic set_mod(input int s, input int pres, input int d31, input int b5,
                         input int col, input int w, input int sa = 'h75, input int sb = 'h54);
    for (int i = 0; i < 256; i++) mem[s][i] = '0;
    mem[s][2] = pres ? 8'h04 : 8'h08;
    mem[s][9] = 8'(sa); mem[s][10] = 8'(sb); mem[s][31] = 8'(d31);
    mem[s][5] = 8'(b5); mem[s][4] = 8'(col); mem[s][6] = 8'(w);
  endtask

  // reference from the requirements
  task automatic model();
    int base, s1, s2, d, b, c, kb, idx;
    longint pg;
    base = 0; exp_err = 0; exp_sock = 0; exp_cause = 0;
    q_sock.delete(); q_idx.delete();
    foreach (exp_bnd[k]) exp_bnd[k] = 0;
    exp_attr[0] = 'hFF; exp_attr[1] = 'hFF;
    for (int s = 0; s < 2; s++) begin
      q_sock.push_back(s); q_idx.push_back(2);
      if (mem[s][2] != 8'h04) begin
        exp_bnd[2*s] = base; exp_bnd[2*s+1] = base;
        continue;
      end
      q_sock.push_back(s); q_idx.push_back(9);
      q_sock.push_back(s); q_idx.push_back(10);
      q_sock.push_back(s); q_idx.push_back(31);
      q_sock.push_back(s); q_idx.push_back(5);
      q_sock.push_back(s); q_idx.push_back(4);
      q_sock.push_back(s); q_idx.push_back(6);
      d = mem[s][31]; b = mem[s][5];
      s1 = 0; s2 = 0;
      for (int i = 512; i > 0; i >>= 1) if ((d & i) != 0) begin s1 = i; break; end
      if (b > 1) begin
        if (d == s1) s2 = s1;
        else for (int i = s1 >> 1; i > 0; i >>= 1) if (d == (s1 | i)) begin s2 = i; break; end
      end
      if (s2 != 0 && s2 != s1) s2 = 0;
      s1 *= 4; s2 *= 4;
      if (mem[s][4] > 30) kb = -1;
      else begin pg = (longint'(1) << mem[s][4]) * mem[s][6]; kb = int'(pg / 8 / 1024); end
      idx = -1;
      if (kb == 2) idx = 0; else if (kb == 4) idx = 1; else if (kb == 8) idx = 2; else if (kb == 16) idx = 3;
      c = 0;
      if (mem[s][9] != 8'h75) c = 1;
      else if (mem[s][10] != 8'h54) c = 2;
      else if (s1 < 32) c = 3;
      else if (s1 > 256) c = 4;
      else if (b != 1 && b != 2) c = 5;
      else if (idx < 0) c = 6;
      if (c != 0) begin exp_err = 1; exp_sock = s; exp_cause = c; return; end
      exp_bnd[2*s] = base + s1 / 32;
      exp_bnd[2*s+1] = base + (s1 + s2) / 32;
      base = exp_bnd[2*s+1];
      exp_attr[s] = (b == 1) ? ('hF0 + idx) : (idx * 'h11);
    end
    exp_bnd[4] = base; exp_bnd[5] = base;
  endtask

  task automatic run_case(input string name, input int lat);
    int wc, guard;
    bit fin;
    model();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    wc = 0; fin = 0; guard = 0;
    while (!fin && guard < 2000) begin
      if (rd_valid_i) rd_valid_i = 1'b0;
      else if (rd_req_o) begin
        if (wc < lat) wc++;
        else begin
          wc = 0;
          if (q_idx.size() == 0) chk(0, {name, " R1 extra read"}, rd_idx_o, 0);
          else begin
            chk(rd_idx_o == 8'(q_idx[0]) && rd_sock_o == 1'(q_sock[0]),
                {name, " R1 read order"}, {rd_sock_o, rd_idx_o}, (q_sock[0] << 8) | q_idx[0]);
            void'(q_idx.pop_front()); void'(q_sock.pop_front());
          end
          rd_data_i = mem[rd_sock_o][rd_idx_o];
          rd_valid_i = 1'b1;
        end
      end
      // every-clock: no early termination flags
      if (done_o || err_o) fin = 1;
      else begin @(negedge clk_i); guard++; end
    end
    chk(q_idx.size() == 0, {name, " R1 all reads issued"}, q_idx.size(), 0);
    if (exp_err) begin
      chk(err_o && !done_o, {name, " R10 error flag"}, {done_o, err_o}, 1);
      chk(err_cause_o == 3'(exp_cause), {name, " R4/R5/R9 cause"}, err_cause_o, exp_cause);
      chk(err_sock_o == 1'(exp_sock), {name, " R10 socket"}, err_sock_o, exp_sock);
      repeat (3) begin
        @(negedge clk_i);
        chk(!rd_req_o && err_o && err_cause_o == 3'(exp_cause), {name, " R10 stopped"},
            {rd_req_o, err_o}, 1);
      end
    end else begin
      chk(done_o && !err_o, {name, " R11 done"}, {done_o, err_o}, 2);
    end
    for (int k = 0; k < 6; k++)
      chk(bnd_o[k*8 +: 8] == 8'(exp_bnd[k]), {name, $sformatf(" R6/R7 bnd%0d", k)},
          bnd_o[k*8 +: 8], exp_bnd[k]);
    for (int s = 0; s < 2; s++)
      chk(attr_o[s*8 +: 8] == 8'(exp_attr[s]), {name, $sformatf(" R8/R2 attr%0d", s)},
          attr_o[s*8 +: 8], exp_attr[s]);
    if (!exp_err) begin
      @(negedge clk_i);
      chk(!done_o, {name, " R11 pulse width"}, done_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!rd_req_o && !done_o && !err_o, "R12 reset flags", {rd_req_o, done_o, err_o}, 0);
    chk(bnd_o == '0, "R12 reset bnd", int'(bnd_o[31:0]), 0);
    chk(attr_o == 16'hFFFF, "R12 reset attr", attr_o, 'hFFFF);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R3 symmetric dual, single bank
    set_mod(0, 1, 'h20, 2, 9, 64);  set_mod(1, 1, 'h10, 1, 10, 64);
    run_case("sym", 0);
    // R2 R3 empty then asymmetric demoted
    set_mod(0, 0, 0, 0, 0, 0);      set_mod(1, 1, 'h30, 2, 8, 64);
    run_case("asym", 2);
    set_mod(0, 0, 0, 0, 0, 0);      set_mod(1, 0, 0, 0, 0, 0);
    run_case("empty", 1);
    // R3 three-bit density, R5 lower limit 32MB accepted
    set_mod(0, 1, 'h38, 2, 11, 16); set_mod(1, 1, 'h08, 2, 9, 32);
    run_case("tribit", 0);
    // R5 upper limit 256MB accepted, 16KB pages
    set_mod(0, 1, 'h40, 2, 11, 64); set_mod(1, 1, 'h40, 1, 11, 64);
    run_case("max", 1);
    // R4 byte 9 on socket 1, size also bad: speed wins
    set_mod(0, 1, 'h10, 1, 8, 64);  set_mod(1, 1, 'h04, 1, 8, 64, 'h70);
    run_case("speed_a", 0);
    set_mod(0, 1, 'h10, 1, 8, 64, 'h75, 'h50);
    run_case("speed_b", 2);
    // R5 too small / too large
    set_mod(0, 1, 'h04, 1, 8, 64);
    run_case("small", 0);
    set_mod(0, 1, 'h80, 1, 8, 64);
    run_case("large", 1);
    // R9 bank count outranks page size
    set_mod(0, 1, 'h10, 3, 12, 64);
    run_case("banks", 0);
    set_mod(0, 1, 'h10, 2, 12, 64);
    run_case("page", 0);
    // R11 start clears the error
    set_mod(0, 1, 'h10, 1, 8, 64);  set_mod(1, 0, 0, 0, 0, 0);
    run_case("recover", 1);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule